// File: doc/BRIEF.md
# Attempt-Limited Code Lock Controller

This block guards a door with a fixed 4-bit combination. Each time the user presses the enter button, an already debounced single-cycle pulse arrives. On that pulse the block compares the 4-bit code word with a password that is fixed as a parameter. A match lights the green indicator, and the four seven-segment characters spell OPEN. A mismatch adds one to an internal 3-bit failure count. A correct entry does not clear that count.

Once the failure count equals the configured limit, the block enters lockout and stays there until a synchronous reset. In lockout the red indicator is lit, the characters spell BLOC, and every further entry is ignored, including one with the correct code. The count itself never leaves the block. Only the lockout state derived from it is visible. All outputs come from registers and change on the clock edge that samples the enter pulse.

Top module: `code_lock_ctl`

## Requirements
- R1: While `rst` is high at a clock edge, the failure count is cleared, lockout ends, both indicators go low and all four characters show blank (`7'b1111111`) after that edge.
- R2: An edge with `enter` high, no lockout and `code_in == KEY` sets `unlock_led` to 1 after that edge. The characters then read O,P,E,N on `seg_d3..seg_d0`. The encodings are active low in gfedcba order: O=`7'b1000000`, P=`7'b0001100`, E=`7'b0000110`, N=`7'b1001000`.
- R3: An edge with `enter` high, no lockout and `code_in != KEY` clears `unlock_led` and adds one to the failure count.
- R4: On an edge with `enter` low, no output and no internal state changes, whatever `code_in` holds.
- R5: When the failure count reaches `LIMIT`, `lockout_led` is 1 and `unlock_led` is 0. The characters read B,L,O,C on `seg_d3..seg_d0`: B=`7'b0000011`, L=`7'b1000111`, O=`7'b1000000`, C=`7'b1000110`.
- R6: While in lockout, enter pulses have no effect, whether the code is correct or wrong. The outputs keep showing lockout until reset.
- R7: After a correct entry, OPEN and the green indicator hold through idle cycles until the next enter pulse or reset.
- R8: A correct entry leaves the failure count unchanged. Wrong entries made before and after it add up toward `LIMIT`.
- R9: When neither unlock nor lockout is active, all four characters are blank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| code_in | input | 4 | Entered combination |
| enter | input | 1 | One-cycle enter pulse |
| unlock_led | output | 1 | Green indicator |
| lockout_led | output | 1 | Red indicator |
| seg_d3 | output | 7 | Leftmost character, active low, gfedcba |
| seg_d2 | output | 7 | Second character |
| seg_d1 | output | 7 | Third character |
| seg_d0 | output | 7 | Rightmost character |

## Verification
Two functions can fall in the same cycle: closing an open lock and entering lockout. The wrong entry that brings the count to `LIMIT` must drop the green indicator and OPEN, and raise the red indicator and BLOC, on the same edge. The bench provokes this by placing a correct entry just before the final wrong one. It then compares the next sampled output word against the model, which expects green 0, red 1 and BLOC in one step. A correct code entered right after that edge must still leave the lock closed.

// File: rtl/code_lock_ctl.sv
module code_lock_ctl #(
  parameter logic [3:0]  KEY   = 4'b1011,
  parameter int unsigned LIMIT = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] code_in,
  input  logic       enter,
  output logic       unlock_led,
  output logic       lockout_led,
  output logic [6:0] seg_d3,
  output logic [6:0] seg_d2,
  output logic [6:0] seg_d1,
  output logic [6:0] seg_d0
);
  localparam int CW = 3;
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  localparam logic [6:0] CH_BLANK = 7'b1111111;
  localparam logic [6:0] CH_O     = 7'b1000000;
  localparam logic [6:0] CH_P     = 7'b0001100;
  localparam logic [6:0] CH_E     = 7'b0000110;
  localparam logic [6:0] CH_N     = 7'b1001000;
  localparam logic [6:0] CH_B     = 7'b0000011;
  localparam logic [6:0] CH_L     = 7'b1000111;
  localparam logic [6:0] CH_C     = 7'b1000110;

  logic [CW-1:0] fails;
  logic          opened;
  logic          at_limit, match, take;

  assign at_limit = (fails == LIM);
  assign match    = (code_in == KEY);
  assign take     = enter & ~at_limit;

  always_ff @(posedge clk) begin
    if (rst) begin
      fails  <= '0;
      opened <= 1'b0;
    end else if (take) begin
      opened <= match;
      if (!match) fails <= fails + 1'b1;
    end
  end

  assign unlock_led  = opened & ~at_limit;
  assign lockout_led = at_limit;

  always_comb begin
    if (at_limit) begin
      {seg_d3, seg_d2, seg_d1, seg_d0} = {CH_B, CH_L, CH_O, CH_C};
    end else if (opened) begin
      {seg_d3, seg_d2, seg_d1, seg_d0} = {CH_O, CH_P, CH_E, CH_N};
    end else begin
      {seg_d3, seg_d2, seg_d1, seg_d0} = {4{CH_BLANK}};
    end
  end
endmodule

// File: rtl/code_lock_chk.sv
module code_lock_chk #(
  parameter logic [3:0]  KEY   = 4'b1011,
  parameter int unsigned LIMIT = 3
) (
  input logic       clk,
  input logic       rst,
  input logic [3:0] code_in,
  input logic       enter,
  input logic       unlock_led,
  input logic       lockout_led,
  input logic [6:0] seg_d3,
  input logic [6:0] seg_d2,
  input logic [6:0] seg_d1,
  input logic [6:0] seg_d0
);
  initial assert_limit_range_R5: assert (LIMIT >= 1 && LIMIT <= 7);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!unlock_led && !lockout_led));

  assert_open_on_match_R2: assert property (@(posedge clk) disable iff (rst)
    (enter && !lockout_led && code_in == KEY) |=> unlock_led);

  assert_close_on_miss_R3: assert property (@(posedge clk) disable iff (rst)
    (enter && code_in != KEY) |=> !unlock_led);

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !enter |=> ($stable(unlock_led) && $stable(lockout_led) && $stable(seg_d3) && $stable(seg_d0)));

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(unlock_led && lockout_led));

  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    lockout_led |=> (lockout_led && !unlock_led));

  assert_blank_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!unlock_led && !lockout_led) |-> ({seg_d3, seg_d2, seg_d1, seg_d0} == {4{7'b1111111}}));
endmodule

bind code_lock_ctl code_lock_chk #(.KEY(KEY), .LIMIT(LIMIT)) u_chk (
  .clk(clk), .rst(rst), .code_in(code_in), .enter(enter),
  .unlock_led(unlock_led), .lockout_led(lockout_led),
  .seg_d3(seg_d3), .seg_d2(seg_d2), .seg_d1(seg_d1), .seg_d0(seg_d0)
);

// File: tb/sim_code_lock_ctl.sv
module sim_code_lock_ctl;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] KEY = 4'b1011;
  localparam int LIMIT = 3;
  localparam logic [27:0] W_OPEN  = {7'b1000000, 7'b0001100, 7'b0000110, 7'b1001000};
  localparam logic [27:0] W_BLOC  = {7'b0000011, 7'b1000111, 7'b1000000, 7'b1000110};
  localparam logic [27:0] W_BLANK = {4{7'b1111111}};

  typedef struct {
    logic        unl;
    logic        lck;
    logic [27:0] segs;
    string       tag;
  } item_t;

  logic clk = 0, rst = 0, enter = 0;
  logic [3:0] code_in = 0;
  logic unlock_led, lockout_led;
  logic [6:0] seg_d3, seg_d2, seg_d1, seg_d0;

  item_t q[$];
  int checks = 0, fails = 0, m_fail = 0;
  bit m_open = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  code_lock_ctl #(.KEY(KEY), .LIMIT(LIMIT)) u0 (
    .clk(clk), .rst(rst), .code_in(code_in), .enter(enter),
    .unlock_led(unlock_led), .lockout_led(lockout_led),
    .seg_d3(seg_d3), .seg_d2(seg_d2), .seg_d1(seg_d1), .seg_d0(seg_d0)
  );

  task automatic step(input bit r, input bit en, input logic [3:0] c, input string tag);
    item_t it;
    @(negedge clk);
    rst = r; enter = en; code_in = c;
    if (r) begin
      m_fail = 0; m_open = 0;
    end else if (en && m_fail < LIMIT) begin
      m_open = (c == KEY);
      if (c != KEY) m_fail++;
    end
    it.lck  = (m_fail >= LIMIT);
    it.unl  = m_open && !it.lck;
    it.segs = it.lck ? W_BLOC : (it.unl ? W_OPEN : W_BLANK);
    it.tag  = tag;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (q.size() > 0) begin
      item_t e;
      logic [27:0] act;
      e = q.pop_front();
      act = {seg_d3, seg_d2, seg_d1, seg_d0};
      checks++;
      if (unlock_led !== e.unl || lockout_led !== e.lck || act !== e.segs) begin
        fails++;
        $display("FAIL %s: got unl=%b lck=%b seg=%h, expected unl=%b lck=%b seg=%h",
                 e.tag, unlock_led, lockout_led, act, e.unl, e.lck, e.segs);
      end
    end
  end

  initial begin
    step(1, 0, 4'h0, "R1 reset");
    step(0, 0, KEY,  "R4 idle key no enter");
    step(0, 0, 4'h3, "R9 blank idle");
    step(0, 1, KEY,  "R2 correct opens");
    step(0, 0, 4'h0, "R7 open held");
    step(0, 0, 4'h5, "R7 open held 2");
    step(0, 1, 4'h2, "R3 wrong closes");
    step(0, 1, KEY,  "R8 correct keeps count");
    step(0, 1, 4'h0, "R3 second wrong");
    step(0, 0, 4'h1, "R4 idle wrong no enter");
    step(0, 1, KEY,  "R2 reopen before limit");
    step(0, 1, 4'hF, "R5 limit reached from open");
    step(0, 1, KEY,  "R6 correct ignored in lockout");
    step(0, 1, 4'h4, "R6 wrong ignored in lockout");
    step(0, 0, KEY,  "R6 lockout held");
    step(1, 1, KEY,  "R1 reset beats enter");
    step(0, 1, 4'h7, "R3 wrong after reset");
    step(0, 1, 4'h6, "R3 wrong two");
    step(0, 1, KEY,  "R8 open with two fails");
    step(0, 1, 4'h8, "R5 third wrong locks");
    step(0, 1, KEY,  "R6 still locked");
    step(1, 0, 4'h0, "R1 reset clears lockout");
    step(0, 1, KEY,  "R2 opens after reset");
    step(0, 0, 4'h0, "R9 flush");
    @(negedge clk);
    @(negedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 2000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule